// File: doc/BRIEF.md
# Indexed Block Register Target for a Two-Wire Management Bus

This block sits on an SMBus/I2C two-wire bus as a target and holds a bank of 24 byte-wide configuration registers. The registers drive the rest of the chip in parallel. Each register also has a one-cycle write strobe, so downstream logic can react to a fresh value. A host changes registers with an indexed block write. It sends the write address, a starting index, a byte count and that many data bytes. Each byte lands in the next register.

A host reads with an indexed block read. It writes the starting index, issues a repeated start and then the read address. The target first returns the read-count byte held in register 8, then consecutive registers from the index. This continues until the host answers a byte with NACK. A few register bits are fixed identification values. Five bits of register 1 reflect strap pins that are captured while reset is held. SCL and SDA are sampled through synchronisers on the system clock. SDA is driven only as an open-drain pull-low enable.

Top module: `smb_cfg_target`

## Requirements
- R1: The address byte 0xD2 (write) and 0xD3 (read) is acknowledged. Any other address byte is not acknowledged, and no later byte is acknowledged until the next start condition.
- R2: In a write, the index byte and the count byte are acknowledged. Each data byte within the count is acknowledged and stored in register index+k, where k counts the data bytes from 0.
- R3: A data byte sent after the count is used up is not acknowledged and changes no register.
- R4: After a repeated start and 0xD3, the first byte returned is the value of register 8. The values of registers index, index+1 and so on follow, MSB first.
- R5: The target keeps returning bytes while the host acknowledges and releases SDA after the host's NACK. The pull-low enable changes only while the synchronised SCL is low, except when it is released on a start or stop.
- R6: After reset, register 8 reads 0x0F, register 7 reads 0x22 and register 6 reads 0x01. Register 1 bits [7:5] read 3'b111, and every other register reads 0x00.
- R7: Writes do not change register 7, register 6 bits [3:0] or register 1 bits [4:0]. Register 6 bits [7:4] and register 1 bits [7:5] take the written value.
- R8: Register 1 bits [4:0] hold the strap input value sampled during reset and ignore later strap changes.
- R9: The index advances by one after each data byte. A write to an index of 24 or above is acknowledged but dropped without a strobe, and a read there returns 0x00.
- R10: Each stored data byte pulses exactly one bit of reg_wr_o, the bit of its register, for one cycle. That register changes only in that cycle.
- R11: A stop condition ends any transfer and releases SDA. A following transaction then works normally and uses the index left by the aborted one.
- R12: Register 8 is writable, and its new value is the count byte of the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; strap pins are captured while it is high |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | When high, the data line is pulled low |
| strap_i | input | 5 | Strap pin levels, captured into register 1 bits [4:0] |
| reg_flat_o | output | 192 | Register contents, register i at bits [8i+7:8i] |
| reg_wr_o | output | 24 | One-cycle write strobe per register |

## Verification
The bench targets these corner cases and the failure each one would expose:
- **Data past the byte count.** A design that ignored the count would acknowledge the extra byte and overwrite the neighbouring register.
- **Writes and reads that run past the last register.** A design that wrapped the index would corrupt register 0, and one without an index limit would return stale data instead of 0x00.
- **Read-only fields.** A missing write mask would let a write replace the device ID, the vendor nibble or the strap bits.
- **Register 8 as the count byte.** A design returning a fixed count would not follow a reprogrammed register 8.
- **Stop and foreign addresses.** A stop in the middle of a write, and a foreign address, would leave a wrong state machine still acknowledging or still driving SDA.

// File: rtl/smb_cfg_pkg.sv
`timescale 1ns/1ps
package smb_cfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_INDEX,
    ST_COUNT,
    ST_WDATA,
    ST_ACK,
    ST_TX,
    ST_HACK
  } smb_state_e;
endpackage

// File: rtl/smb_line_sync.sv
`timescale 1ns/1ps
module smb_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[SYNC_STAGES-1];
      sda_q    <= sda_pipe[SYNC_STAGES-1];
    end
  end

  assign scl_lvl   = scl_pipe[SYNC_STAGES-1];
  assign sda_lvl   = sda_pipe[SYNC_STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_q;
  assign scl_fall  = ~scl_lvl & scl_q;
  // data edges while the clock line stays high mark start and stop
  assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/smb_cfg_regbank.sv
`timescale 1ns/1ps
module smb_cfg_regbank #(
  parameter int              NUM_REGS  = 24,
  parameter int              DATA_W    = 8,
  parameter int              STRAP_W   = 5,
  parameter int              STRAP_IDX = 1,
  parameter int              VEND_IDX  = 6,
  parameter int              ID_IDX    = 7,
  parameter int              CNT_IDX   = 8,
  parameter logic [DATA_W-1:0] DEV_ID    = 8'h22,
  parameter logic [DATA_W-1:0] VEND_MASK = 8'h0F,
  parameter logic [DATA_W-1:0] VEND_VAL  = 8'h01,
  parameter logic [DATA_W-1:0] CNT_RST   = 8'h0F,
  parameter logic [DATA_W-1:0] STRAP_HI  = 8'hE0,
  localparam int             IDX_W     = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [STRAP_W-1:0]         strap_i,
  output logic [NUM_REGS*DATA_W-1:0] regs_o,
  output logic [NUM_REGS-1:0]        strobe_o
);
  localparam logic [DATA_W-1:0] STRAP_MASK = DATA_W'((1 << STRAP_W) - 1);

  function automatic logic [DATA_W-1:0] rst_of(input int i);
    if (i == CNT_IDX)   return CNT_RST;
    if (i == ID_IDX)    return DEV_ID;
    if (i == VEND_IDX)  return VEND_VAL;
    if (i == STRAP_IDX) return STRAP_HI;
    return '0;
  endfunction

  function automatic logic [DATA_W-1:0] wmask_of(input int i);
    if (i == ID_IDX)    return '0;
    if (i == VEND_IDX)  return ~VEND_MASK;
    if (i == STRAP_IDX) return ~STRAP_MASK;
    return '1;
  endfunction

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [DATA_W-1:0] RSTV  = rst_of(g);
    localparam logic [DATA_W-1:0] WMASK = wmask_of(g);
    localparam logic [DATA_W-1:0] SMASK = (g == STRAP_IDX) ? STRAP_MASK : '0;
    logic [DATA_W-1:0] q;

    always_ff @(posedge clk) begin
      if (rst)
        q <= RSTV | (SMASK & DATA_W'(strap_i));
      else if (wr_en && wr_idx == IDX_W'(g))
        q <= (q & ~WMASK) | (wr_data & WMASK);
    end

    always_ff @(posedge clk) begin
      if (rst) strobe_o[g] <= 1'b0;
      else     strobe_o[g] <= wr_en && (wr_idx == IDX_W'(g));
    end

    assign regs_o[g*DATA_W +: DATA_W] = q;
  end
endmodule

// File: rtl/smb_cfg_target.sv
`timescale 1ns/1ps
module smb_cfg_target
  import smb_cfg_pkg::*;
#(
  parameter int          NUM_REGS    = 24,
  parameter int          DATA_W      = 8,
  parameter int          STRAP_W     = 5,
  parameter int          SYNC_STAGES = 2,
  parameter logic [6:0]  DEV_ADDR    = 7'h69,
  parameter int          CNT_IDX     = 8,
  localparam int         IDX_W       = $clog2(NUM_REGS),
  localparam int         FLAT_W      = NUM_REGS * DATA_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] strap_i,
  output logic [FLAT_W-1:0]  reg_flat_o,
  output logic [NUM_REGS-1:0] reg_wr_o
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

  smb_line_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  smb_state_e        state, nxt;
  logic [DATA_W-1:0] shreg, ptr, wleft, wr_data;
  logic [3:0]        bitcnt;
  logic              oe, host_nack, wr_en;
  logic [IDX_W-1:0]  wr_idx;

  smb_cfg_regbank #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .STRAP_W(STRAP_W), .CNT_IDX(CNT_IDX)
  ) bank_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .strap_i(strap_i), .regs_o(reg_flat_o), .strobe_o(reg_wr_o)
  );

  logic [DATA_W-1:0] reg_arr [NUM_REGS];
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_unpack
    assign reg_arr[g] = reg_flat_o[g*DATA_W +: DATA_W];
  end

  logic              ptr_ok;
  logic [DATA_W-1:0] rd_val, cnt_val;
  assign ptr_ok  = ptr < DATA_W'(NUM_REGS);
  assign rd_val  = ptr_ok ? reg_arr[ptr[IDX_W-1:0]] : '0;
  assign cnt_val = reg_arr[CNT_IDX];

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      nxt       <= ST_IDLE;
      shreg     <= '0;
      ptr       <= '0;
      wleft     <= '0;
      bitcnt    <= '0;
      oe        <= 1'b0;
      host_nack <= 1'b0;
      wr_en     <= 1'b0;
      wr_idx    <= '0;
      wr_data   <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        oe     <= 1'b0;
      end else if (stop_det) begin
        state <= ST_IDLE;
        oe    <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_INDEX, ST_COUNT, ST_WDATA: begin
            if (scl_rise && bitcnt != 4'd8) begin
              shreg  <= {shreg[DATA_W-2:0], sda_lvl};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              case (state)
                ST_ADDR: begin
                  if (shreg == {DEV_ADDR, 1'b0}) begin
                    oe <= 1'b1; nxt <= ST_INDEX; state <= ST_ACK;
                  end else if (shreg == {DEV_ADDR, 1'b1}) begin
                    oe <= 1'b1; nxt <= ST_TX; state <= ST_ACK;
                  end else begin
                    state <= ST_IDLE;
                  end
                end
                ST_INDEX: begin
                  ptr <= shreg;
                  oe <= 1'b1; nxt <= ST_COUNT; state <= ST_ACK;
                end
                ST_COUNT: begin
                  wleft <= shreg;
                  oe <= 1'b1; nxt <= ST_WDATA; state <= ST_ACK;
                end
                default: begin
                  if (wleft != '0) begin
                    wleft <= wleft - DATA_W'(1);
                    ptr   <= ptr + DATA_W'(1);
                    if (ptr_ok) begin
                      wr_en   <= 1'b1;
                      wr_idx  <= ptr[IDX_W-1:0];
                      wr_data <= shreg;
                    end
                    oe <= 1'b1; nxt <= ST_WDATA; state <= ST_ACK;
                  end else begin
                    state <= ST_IDLE;
                  end
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (nxt == ST_TX) begin
                shreg  <= cnt_val;
                oe     <= ~cnt_val[DATA_W-1];
                bitcnt <= '0;
              end else begin
                oe <= 1'b0;
              end
              state <= nxt;
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                oe    <= 1'b0;
                state <= ST_HACK;
              end else begin
                oe     <= ~shreg[DATA_W-2];
                shreg  <= {shreg[DATA_W-2:0], 1'b0};
                bitcnt <= bitcnt + 4'd1;
              end
            end
          end
          ST_HACK: begin
            if (scl_rise) begin
              host_nack <= sda_lvl;
            end else if (scl_fall) begin
              if (host_nack) begin
                state <= ST_IDLE;
              end else begin
                shreg  <= rd_val;
                oe     <= ~rd_val[DATA_W-1];
                ptr    <= ptr + DATA_W'(1);
                bitcnt <= '0;
                state  <= ST_TX;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe = oe;
endmodule

// File: rtl/smb_cfg_target_chk.sv
`timescale 1ns/1ps
module smb_cfg_target_chk #(
  parameter int NUM_REGS  = 24,
  parameter int DATA_W    = 8,
  parameter int CNT_IDX   = 8,
  parameter int STRAP_W   = 5,
  parameter int STRAP_IDX = 1
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       sda_oe,
  input logic                       scl_lvl,
  input logic                       start_det,
  input logic                       stop_det,
  input logic [NUM_REGS-1:0]        reg_wr_o,
  input logic [NUM_REGS*DATA_W-1:0] reg_flat_o
);
  p_sda_edge_scl_low_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> (!scl_lvl || $past(start_det || stop_det)));

  p_strobe_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(reg_wr_o));

  p_strobe_single_r10: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_o != '0) |=> (reg_wr_o == '0));

  p_cnt_change_strobe_r12: assert property (@(posedge clk) disable iff (rst)
    !$stable(reg_flat_o[CNT_IDX*DATA_W +: DATA_W]) |-> reg_wr_o[CNT_IDX]);

  p_strap_hold_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(reg_flat_o[STRAP_IDX*DATA_W +: STRAP_W]));

  p_release_after_stop_r11: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);
endmodule

bind smb_cfg_target smb_cfg_target_chk #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .CNT_IDX(CNT_IDX), .STRAP_W(STRAP_W)
) chk_i (
  .clk(clk), .rst(rst), .sda_oe(sda_oe), .scl_lvl(scl_lvl),
  .start_det(start_det), .stop_det(stop_det),
  .reg_wr_o(reg_wr_o), .reg_flat_o(reg_flat_o)
);

// File: tb/smb_cfg_target_tb_top.sv
`timescale 1ns/1ps
module smb_cfg_target_tb_top;
  localparam int NREG = 24;
  localparam int Q    = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_drv = 1'b1;
  logic host_sda = 1'b1;
  logic [4:0] strap = 5'b10110;
  logic sda_oe;
  logic [NREG*8-1:0] regs;
  logic [NREG-1:0] wr;
  wire  sda_line = host_sda & ~sda_oe;

  always #5 clk = ~clk;

  smb_cfg_target dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_drv), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_i(strap), .reg_flat_o(regs), .reg_wr_o(wr)
  );

  int total = 0, bad = 0;
  bit done = 0;
  int stb_cnt [NREG];
  int stb_all = 0;
  logic [7:0] rbuf [8];
  logic [7:0] wbuf [8];

  initial for (int i = 0; i < NREG; i++) stb_cnt[i] = 0;
  always @(negedge clk) if (!rst)
    for (int i = 0; i < NREG; i++) if (wr[i]) begin stb_cnt[i]++; stb_all++; end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hq(); repeat (Q) @(negedge clk); endtask
  task automatic bus_start();
    host_sda = 1; hq(); scl_drv = 1; hq(); host_sda = 0; hq(); scl_drv = 0; hq();
  endtask
  task automatic bus_stop();
    host_sda = 0; hq(); scl_drv = 1; hq(); host_sda = 1; hq();
  endtask
  task automatic put_bit(input logic b);
    host_sda = b; hq(); scl_drv = 1; hq(); hq(); scl_drv = 0; hq();
  endtask
  task automatic get_bit(output logic b);
    host_sda = 1; hq(); scl_drv = 1; hq(); b = sda_line; hq(); scl_drv = 0; hq();
  endtask
  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = ~b;
  endtask
  task automatic recv_byte(output logic [7:0] d, input logic nack);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    put_bit(nack);
  endtask

  task automatic blk_write(input logic [7:0] idx, input logic [7:0] cnt, input int nsend);
    logic ack;
    bus_start();
    send_byte(8'hD2, ack); chk(ack, "R1 write address ack", ack, 1);
    send_byte(idx, ack);   chk(ack, "R2 index ack", ack, 1);
    send_byte(cnt, ack);   chk(ack, "R2 count ack", ack, 1);
    for (int i = 0; i < nsend; i++) begin
      send_byte(wbuf[i], ack);
      if (i < cnt) chk(ack == 1'b1, "R2 data ack", ack, 1);
      else         chk(ack == 1'b0, "R3 data past count nack", ack, 0);
      if (!ack) break;
    end
    bus_stop();
  endtask

  task automatic blk_read(input bit use_idx, input logic [7:0] idx, input int n);
    logic ack;
    bus_start();
    if (use_idx) begin
      send_byte(8'hD2, ack); chk(ack, "R1 write address ack", ack, 1);
      send_byte(idx, ack);   chk(ack, "R2 index ack", ack, 1);
      bus_start();
    end
    send_byte(8'hD3, ack); chk(ack, "R1 read address ack", ack, 1);
    for (int i = 0; i < n; i++) recv_byte(rbuf[i], i == n - 1);
    bus_stop();
  endtask

  // {index, write data, expected read-back}
  localparam logic [23:0] VEC [9] = '{
    {8'h00, 8'hA5, 8'hA5}, {8'h05, 8'h3C, 8'h3C}, {8'h17, 8'h81, 8'h81},
    {8'h07, 8'hFF, 8'h22}, {8'h01, 8'h00, 8'h16}, {8'h06, 8'hF0, 8'hF1},
    {8'h06, 8'h0E, 8'h01}, {8'h1E, 8'h77, 8'h00}, {8'h0C, 8'h5A, 8'h5A}
  };

  initial begin
    #1_500_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic ack;
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (3) @(negedge clk);
    strap = 5'b01001;
    // R6 R8 reset state
    chk(regs[8*8 +: 8] == 8'h0F, "R6 reg8 reset", regs[8*8 +: 8], 8'h0F);
    chk(regs[7*8 +: 8] == 8'h22, "R6 reg7 reset", regs[7*8 +: 8], 8'h22);
    chk(regs[6*8 +: 8] == 8'h01, "R6 reg6 reset", regs[6*8 +: 8], 8'h01);
    chk(regs[1*8 +: 8] == 8'hF6, "R8 reg1 reset strap", regs[1*8 +: 8], 8'hF6);
    chk(regs[0 +: 8] == 8'h00, "R6 reg0 reset", regs[0 +: 8], 0);
    chk(sda_oe == 0 && wr == '0, "R6 idle outputs", {sda_oe, wr}, 0);

    for (int v = 0; v < 9; v++) begin
      logic [7:0] idx, dat, exp;
      int s0, sa0;
      string tag;
      {idx, dat, exp} = VEC[v];
      tag = (idx >= NREG) ? "R9" : ((idx == 1 || idx == 6 || idx == 7) ? "R7" : "R2");
      sa0 = stb_all;
      s0 = (idx < NREG) ? stb_cnt[idx] : 0;
      wbuf[0] = dat;
      blk_write(idx, 8'd1, 1);
      if (idx < NREG) begin
        chk(regs[idx*8 +: 8] == exp, tag, regs[idx*8 +: 8], exp);
        chk(stb_cnt[idx] - s0 == 1 && stb_all - sa0 == 1, "R10 one strobe", stb_all - sa0, 1);
      end else begin
        chk(stb_all == sa0, "R9 no strobe out of range", stb_all - sa0, 0);
      end
      blk_read(1, idx, 2);
      chk(rbuf[0] == 8'h0F, "R4 count byte", rbuf[0], 8'h0F);
      chk(rbuf[1] == exp, tag, rbuf[1], exp);
    end
    chk(sda_oe == 0, "R5 released after host nack", sda_oe, 0);

    // R3 data beyond count, R4 R5 consecutive read
    wbuf[0] = 8'h91; wbuf[1] = 8'h92; wbuf[2] = 8'h93; wbuf[3] = 8'h94;
    blk_write(8'd9, 8'd3, 4);
    chk(regs[12*8 +: 8] == 8'h5A, "R3 reg12 untouched", regs[12*8 +: 8], 8'h5A);
    blk_read(1, 8'd9, 5);
    chk(rbuf[0] == 8'h0F, "R4 count byte", rbuf[0], 8'h0F);
    chk(rbuf[1] == 8'h91, "R4 reg9", rbuf[1], 8'h91);
    chk(rbuf[2] == 8'h92, "R5 reg10", rbuf[2], 8'h92);
    chk(rbuf[3] == 8'h93, "R5 reg11", rbuf[3], 8'h93);
    chk(rbuf[4] == 8'h5A, "R5 reg12", rbuf[4], 8'h5A);

    // R12 reprogrammed count byte
    wbuf[0] = 8'h03;
    blk_write(8'd8, 8'd1, 1);
    blk_read(1, 8'd0, 2);
    chk(rbuf[0] == 8'h03, "R12 count follows reg8", rbuf[0], 8'h03);
    chk(rbuf[1] == 8'hA5, "R4 reg0", rbuf[1], 8'hA5);
    wbuf[0] = 8'h0F;
    blk_write(8'd8, 8'd1, 1);

    // R1 foreign address
    bus_start();
    send_byte(8'hA4, ack); chk(ack == 0, "R1 foreign address nack", ack, 0);
    send_byte(8'hD2, ack); chk(ack == 0, "R1 silent until start", ack, 0);
    bus_stop();

    // R9 run past the last register
    begin
      int sa0;
      sa0 = stb_all;
      wbuf[0] = 8'h61; wbuf[1] = 8'h62; wbuf[2] = 8'h63;
      blk_write(8'd22, 8'd3, 3);
      chk(stb_all - sa0 == 2, "R9 strobes in range only", stb_all - sa0, 2);
      chk(regs[0 +: 8] == 8'hA5, "R9 no wrap to reg0", regs[0 +: 8], 8'hA5);
      blk_read(1, 8'd22, 4);
      chk(rbuf[1] == 8'h61 && rbuf[2] == 8'h62, "R9 reg22 reg23", {rbuf[1], rbuf[2]}, 16'h6162);
      chk(rbuf[3] == 8'h00, "R9 read beyond end", rbuf[3], 0);
    end

    // R11 stop in the middle of a write
    bus_start();
    send_byte(8'hD2, ack);
    send_byte(8'd4, ack);
    send_byte(8'd2, ack);
    send_byte(8'h44, ack);
    bus_stop();
    chk(regs[4*8 +: 8] == 8'h44, "R11 byte before stop kept", regs[4*8 +: 8], 8'h44);
    chk(sda_oe == 0, "R11 released after stop", sda_oe, 0);
    blk_read(0, 8'd0, 2);
    chk(rbuf[1] == 8'h3C, "R11 next read from index 5", rbuf[1], 8'h3C);

    // R8 strap changed after reset
    blk_read(1, 8'd1, 2);
    chk(rbuf[1] == 8'h16, "R8 strap held", rbuf[1], 8'h16);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule